// File: doc/BRIEF.md
# S/PDIF Input Sample-Rate Classifier

This block samples an S/PDIF line with a fast reference clock and works out which of seven standard audio sample rates is arriving. During each measurement window it tracks the shortest and longest interval between two line transitions. When the window closes, it compares a width metric against a ladder of programmable thresholds and reports a 3-bit rate code. It also reports the longest interval seen and the nominal half-cell period for that rate. An interrupt status bit is set when the rate moves from one valid code to another.

Software loads the window length, the per-mode thresholds and the per-mode half-cell timers through a small write-only register port. It then releases the block's two internal resets and sets the enable bit. Rate codes 0 to 6 stand for 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz. Code 7 means no signal.

Register map (word addresses on `cfg_addr_i`):
- 0, control: bit 0 enable, bit 1 metric select, bit 2 output-side run (active-low reset released when 1), bit 3 input-side run.
- 1, window length in bits 19:0 and interrupt mask in bits 27:20.
- 2 and 3, thresholds.
- 4 and 5, timers.
- 6, write-1-to-clear for the interrupt status.

Top module: `spdif_rate_classifier`

## Requirements
- R1: After rst_ni, mode_o is 7, and width_o, cell_ticks_o, irq_stat_o, irq_o and eval_o are all 0.
- R2: While the block runs with window length W (W ≥ 1), it closes one window every W clock cycles. On each close, eval_o pulses for one cycle and the status outputs update in that same cycle.
- R3: spdif_i passes through a two-flop synchronizer. An interval is the number of clock cycles between two consecutive transitions, and it saturates at 1023. width_o reports the longest interval that ended in the last window.
- R4: A window in which no interval ended reports mode 7, width 0 and cell_ticks 0.
- R5: With metric select set to 1, the metric is twice the shortest interval. The mode is the lowest index i in 0..5 whose threshold satisfies metric ≥ threshold[i]. If no threshold qualifies, the mode is 6.
- R6: With metric select set to 0, the metric is the longest interval, and the same ladder as R5 applies.
- R7: Threshold i is 10 bits wide. Register 2 holds modes 0, 1 and 2 in bits 29:20, 19:10 and 9:0. Register 3 holds modes 3, 4 and 5 in the same positions.
- R8: Timer i is 8 bits wide. Register 4 holds modes 0 to 3 in bytes 3 down to 0. Register 5 holds modes 4, 5 and 6 in bytes 3, 2 and 1. cell_ticks_o shows the timer of the reported mode.
- R9: irq_stat_o bit 2 is set at a window close only when the old and new modes both lie in 0..6 and differ. A change from or to 7 sets nothing.
- R10: Status bits stay set until a write to register 6 clears the bits written as 1. A set in the same cycle as a clear wins.
- R11: irq_o is 1 exactly when some status bit is set and its mask bit is 1.
- R12: With enable at 0, no window closes and the status outputs hold their values.
- R13: With output-side run at 0, the status, the interrupt bits and eval_o are held at their reset values. The input side measures only when enable and both run bits are 1, so input release is effective only after output release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| spdif_i | input | 1 | Asynchronous S/PDIF line |
| mode_o | output | 3 | Detected rate code, 7 for no signal |
| width_o | output | 10 | Longest interval in the last window |
| cell_ticks_o | output | 8 | Timer of the reported mode |
| irq_stat_o | output | 8 | Sticky interrupt status |
| irq_o | output | 1 | OR of masked status bits |
| eval_o | output | 1 | One-cycle pulse at each window close |

## Verification
Several properties are checked on every cycle:
- No window closes while the block is stopped.
- A no-signal code always comes with zero width.
- Status bit 2 only rises on a window close whose old and new codes are distinct valid rates.
- irq_o is never set without a status bit.
- At each close, the shortest interval is no larger than the longest.
- The interval counter holds at its ceiling until a transition.

The bench scenarios show what the properties cannot:
- that each line period lands on the correct rung of the ladder in both metric modes, which depends on the register packing;
- saturation at very long intervals;
- the exact window spacing;
- the write-1-to-clear and masking behaviour;
- the hold effects of disable and of the output-side reset.

// File: rtl/spdif_rate_pkg.sv
package spdif_rate_pkg;
  localparam int NUM_MODES   = 7;
  localparam int MODE_W      = 3;
  localparam int WIDTH_W     = 10;
  localparam int TIMER_W     = 8;
  localparam int WIN_W       = 20;
  localparam int IRQ_W       = 8;
  localparam int IRQ_MODE_BIT = 2;
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = 32;
  localparam int THR_PER_REG = 3;
  localparam int TIM_PER_REG = 4;
  localparam int A_CTRL      = 0;
  localparam int A_WIN       = 1;
  localparam int A_THR       = 2;
  localparam int A_TIM       = 4;
  localparam int A_CLR       = 6;
  localparam logic [MODE_W-1:0] MODE_NONE = 3'd7;

  typedef struct packed {
    logic in_run;
    logic out_run;
    logic min_sel;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/spdif_rate_cfg.sv
module spdif_rate_cfg
  import spdif_rate_pkg::*;
#(
  parameter int NM = NUM_MODES,
  parameter int TW = WIDTH_W,
  parameter int KW = TIMER_W,
  parameter int WW = WIN_W,
  parameter int IW = IRQ_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output ctrl_t                  ctrl_o,
  output logic [WW-1:0]          window_o,
  output logic [IW-1:0]          irq_mask_o,
  output logic [NM-2:0][TW-1:0]  thr_o,
  output logic [NM-1:0][KW-1:0]  timer_o,
  output logic [IW-1:0]          irq_clr_o
);
  ctrl_t         ctrl_q;
  logic [WW-1:0] win_q;
  logic [IW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      win_q  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(A_CTRL)) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      if (addr_i == AW'(A_WIN)) begin
        win_q  <= wdata_i[WW-1:0];
        mask_q <= wdata_i[WW +: IW];
      end
    end
  end

  for (genvar m = 0; m < NM - 1; m++) begin : g_thr
    localparam int Reg = A_THR + m / THR_PER_REG;
    localparam int Lsb = TW * (THR_PER_REG - 1 - (m % THR_PER_REG));
    logic [TW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && addr_i == AW'(Reg)) q <= wdata_i[Lsb +: TW];
    end
    assign thr_o[m] = q;
  end

  for (genvar m = 0; m < NM; m++) begin : g_tim
    localparam int Reg = A_TIM + m / TIM_PER_REG;
    localparam int Lsb = KW * (TIM_PER_REG - 1 - (m % TIM_PER_REG));
    logic [KW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && addr_i == AW'(Reg)) q <= wdata_i[Lsb +: KW];
    end
    assign timer_o[m] = q;
  end

  assign ctrl_o     = ctrl_q;
  assign window_o   = win_q;
  assign irq_mask_o = mask_q;
  assign irq_clr_o  = (we_i && addr_i == AW'(A_CLR)) ? wdata_i[IW-1:0] : '0;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/spdif_window_timer.sv
module spdif_window_timer
  import spdif_rate_pkg::*;
#(
  parameter int WW = WIN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [WW-1:0] window_i,
  output logic          tick_o
);
  logic [WW-1:0] cnt_q;
  logic          last;

  // window of 0 or 1 closes every cycle
  assign last   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, window_i};
  assign tick_o = run_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (last)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spdif_edge_meter.sv
module spdif_edge_meter
  import spdif_rate_pkg::*;
#(
  parameter int TW = WIDTH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          spdif_i,
  input  logic          tick_i,
  output logic          valid_o,
  output logic [TW-1:0] min_o,
  output logic [TW-1:0] max_o
);
  localparam logic [TW-1:0] WMAX = '1;

  logic [2:0]    sync_q;
  logic          edge_det;
  logic          have_prev_q;
  logic [TW-1:0] run_q;
  logic [TW-1:0] min_q, max_q;
  logic          valid_q;
  logic          iv_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], spdif_i};
  end

  assign edge_det = sync_q[1] ^ sync_q[2];
  assign iv_hit   = edge_det && have_prev_q;

  always_comb begin
    min_o   = (iv_hit && run_q < min_q) ? run_q : min_q;
    max_o   = (iv_hit && run_q > max_q) ? run_q : max_q;
    valid_o = valid_q | iv_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      run_q       <= '0;
      min_q       <= WMAX;
      max_q       <= '0;
      valid_q     <= 1'b0;
    end else if (clr_i) begin
      have_prev_q <= 1'b0;
      run_q       <= '0;
      min_q       <= WMAX;
      max_q       <= '0;
      valid_q     <= 1'b0;
    end else begin
      if (edge_det)          run_q <= TW'(1);
      else if (run_q != WMAX) run_q <= run_q + 1'b1;
      if (edge_det) have_prev_q <= 1'b1;
      if (tick_i) begin
        min_q   <= WMAX;
        max_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        min_q   <= min_o;
        max_q   <= max_o;
        valid_q <= valid_o;
      end
    end
  end

  // R3
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == WMAX && !edge_det && !clr_i) |=> run_q == WMAX);
  // R3
  min_le_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && valid_o) |-> min_o <= max_o);
endmodule

// File: rtl/spdif_mode_ladder.sv
module spdif_mode_ladder
  import spdif_rate_pkg::*;
#(
  parameter int NM = NUM_MODES,
  parameter int TW = WIDTH_W,
  parameter int MW = MODE_W
) (
  input  logic                  min_sel_i,
  input  logic                  valid_i,
  input  logic [TW-1:0]         min_i,
  input  logic [TW-1:0]         max_i,
  input  logic [NM-2:0][TW-1:0] thr_i,
  output logic [MW-1:0]         mode_o
);
  logic [TW:0] metric;

  assign metric = min_sel_i ? {min_i, 1'b0} : {1'b0, max_i};

  always_comb begin
    mode_o = MW'(NM - 1);
    for (int i = NM - 2; i >= 0; i--) begin
      if (metric >= {1'b0, thr_i[i]}) mode_o = MW'(i);
    end
    if (!valid_i) mode_o = MODE_NONE;
  end
endmodule

// File: rtl/spdif_rate_classifier.sv
module spdif_rate_classifier
  import spdif_rate_pkg::*;
#(
  parameter int NM = NUM_MODES,
  parameter int TW = WIDTH_W,
  parameter int KW = TIMER_W,
  parameter int WW = WIN_W,
  parameter int IW = IRQ_W,
  parameter int MW = MODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          spdif_i,
  output logic [2:0]    mode_o,
  output logic [9:0]    width_o,
  output logic [7:0]    cell_ticks_o,
  output logic [7:0]    irq_stat_o,
  output logic          irq_o,
  output logic          eval_o
);
  ctrl_t                 ctrl;
  logic [WW-1:0]         window;
  logic [IW-1:0]         irq_mask, irq_clr, irq_set;
  logic [NM-2:0][TW-1:0] thr;
  logic [NM-1:0][KW-1:0] timer;
  logic                  meas_run, tick, valid;
  logic [TW-1:0]         min_w, max_w;
  logic [MW-1:0]         new_mode, mode_q;
  logic [TW-1:0]         width_q;
  logic [IW-1:0]         irq_q;
  logic                  eval_q;

  spdif_rate_cfg #(.NM(NM), .TW(TW), .KW(KW), .WW(WW), .IW(IW)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .window_o(window), .irq_mask_o(irq_mask), .thr_o(thr),
    .timer_o(timer), .irq_clr_o(irq_clr)
  );

  // input side runs only after output side is out of reset
  assign meas_run = ctrl.enable && ctrl.out_run && ctrl.in_run;

  spdif_window_timer #(.WW(WW)) u_win (
    .clk_i, .rst_ni, .run_i(meas_run), .window_i(window), .tick_o(tick)
  );

  spdif_edge_meter #(.TW(TW)) u_meter (
    .clk_i, .rst_ni, .clr_i(!meas_run), .spdif_i, .tick_i(tick),
    .valid_o(valid), .min_o(min_w), .max_o(max_w)
  );

  spdif_mode_ladder #(.NM(NM), .TW(TW), .MW(MW)) u_ladder (
    .min_sel_i(ctrl.min_sel), .valid_i(valid), .min_i(min_w), .max_i(max_w),
    .thr_i(thr), .mode_o(new_mode)
  );

  assign irq_set = (tick && mode_q != MODE_NONE && new_mode != MODE_NONE && new_mode != mode_q)
                   ? (IW'(1) << IRQ_MODE_BIT) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NONE;
      width_q <= '0;
      irq_q   <= '0;
      eval_q  <= 1'b0;
    end else if (!ctrl.out_run) begin
      mode_q  <= MODE_NONE;
      width_q <= '0;
      irq_q   <= '0;
      eval_q  <= 1'b0;
    end else begin
      eval_q <= tick;
      if (tick) begin
        mode_q  <= new_mode;
        width_q <= valid ? max_w : '0;
      end
      irq_q <= (irq_q & ~irq_clr) | irq_set;
    end
  end

  assign mode_o       = mode_q;
  assign width_o      = width_q;
  assign cell_ticks_o = (mode_q == MODE_NONE) ? '0 : timer[mode_q];
  assign irq_stat_o   = irq_q;
  assign irq_o        = |(irq_q & irq_mask);
  assign eval_o       = eval_q;

  // R12
  no_eval_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_run |=> !eval_o);
  // R4
  none_zero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_NONE |-> width_o == '0);
  // R9
  irq_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_stat_o[IRQ_MODE_BIT]) |-> (eval_o && $past(mode_o) != MODE_NONE
                                         && $past(mode_o) != mode_o));
  // R11
  irq_needs_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |irq_stat_o);
endmodule

// File: tb/spdif_rate_classifier_tb.sv
module spdif_rate_classifier_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        spdif_i = 1'b0;
  logic [2:0]  mode_o;
  logic [9:0]  width_o;
  logic [7:0]  cell_ticks_o;
  logic [7:0]  irq_stat_o;
  logic        irq_o;
  logic        eval_o;

  always #2.5 clk_i = ~clk_i;

  spdif_rate_classifier u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .spdif_i,
    .mode_o, .width_o, .cell_ticks_o, .irq_stat_o, .irq_o, .eval_o
  );

  typedef struct {
    int    mode;
    int    width;
    int    ticks;
    int    irq2;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, fails = 0;
  int tim[7] = '{81, 59, 54, 29, 27, 14, 13};
  int thr[6];
  int period = 0, last_p = 0, gcnt = 0;
  int prev_mode = 7, irq_exp = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // line generator: one transition every `period` cycles
  always @(negedge clk_i) begin
    if (period != last_p) begin gcnt = 0; last_p = period; end
    if (period != 0) begin
      gcnt++;
      if (gcnt >= period) begin spdif_i = ~spdif_i; gcnt = 0; end
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (eval_o && q.size() > 0) begin
      e = q.pop_front();
      chk(mode_o == e.mode[2:0], e.tag, "mode", int'(mode_o), e.mode);
      chk(width_o == e.width[9:0], e.tag, "width", int'(width_o), e.width);
      chk(cell_ticks_o == e.ticks[7:0], "R8", "cell_ticks", int'(cell_ticks_o), e.ticks);
      chk(irq_stat_o[2] == e.irq2[0], "R9", "irq_bit2", int'(irq_stat_o[2]), e.irq2);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_evals(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      while (!eval_o) @(negedge clk_i);
    end
  endtask

  function automatic int ladder(input int metric);
    for (int i = 0; i < 6; i++) if (metric >= thr[i]) return i;
    return 6;
  endfunction

  task automatic run_case(input int p, input bit min_sel, input string tag);
    int w, m;
    w = (p > 1023) ? 1023 : p;
    m = (p == 0) ? 7 : ladder(min_sel ? 2 * w : w);
    if (p == 0) w = 0;
    if (prev_mode != 7 && m != 7 && m != prev_mode) irq_exp = 1;
    prev_mode = m;
    period = p;
    wait_evals(2);
    @(posedge clk_i);
    q.push_back('{m, w, (m == 7) ? 0 : tim[m], irq_exp, tag});
    while (q.size() > 0) @(negedge clk_i);
  endtask

  task automatic count_evals(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (eval_o) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 6; i++) thr[i] = tim[i] + tim[i+1];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(mode_o == 3'd7, "R1", "mode", int'(mode_o), 7);
    chk(width_o == 0 && cell_ticks_o == 0, "R1", "width/ticks", int'(width_o), 0);
    chk(irq_stat_o == 0 && !irq_o && !eval_o, "R1", "irq/eval", int'(irq_stat_o), 0);

    // R7 R8 packing
    wr(4, {tim[0][7:0], tim[1][7:0], tim[2][7:0], tim[3][7:0]});
    wr(5, {tim[4][7:0], tim[5][7:0], tim[6][7:0], 8'h00});
    wr(2, {2'b00, thr[0][9:0], thr[1][9:0], thr[2][9:0]});
    wr(3, {2'b00, thr[3][9:0], thr[4][9:0], thr[5][9:0]});
    wr(1, {4'h0, 8'h00, 20'd1000});
    wr(0, 32'hF);

    run_case(0, 1, "R4");
    // R2 window spacing
    wait_evals(1);
    n = 0;
    @(negedge clk_i); n++;
    while (!eval_o) begin @(negedge clk_i); n++; end
    chk(n == 1000, "R2", "window_cycles", n, 1000);

    run_case(81, 1, "R5");
    chk(irq_stat_o[2] == 1'b0, "R9", "no_irq_from_none", int'(irq_stat_o[2]), 0);
    run_case(54, 1, "R7");
    // R11 masked / unmasked
    chk(irq_o == 1'b0, "R11", "irq_masked", int'(irq_o), 0);
    wr(1, {4'h0, 8'h04, 20'd1000});
    @(negedge clk_i);
    chk(irq_o == 1'b1, "R11", "irq_unmasked", int'(irq_o), 1);
    // R10 write-1-to-clear
    wr(6, 32'h0000_0004);
    @(negedge clk_i);
    chk(irq_stat_o == 0, "R10", "irq_cleared", int'(irq_stat_o), 0);
    chk(irq_o == 1'b0, "R10", "irq_o_cleared", int'(irq_o), 0);
    irq_exp = 0;

    run_case(27, 1, "R5");
    run_case(13, 1, "R5");
    run_case(14, 1, "R7");
    wr(0, 32'hD);
    run_case(100, 0, "R6");
    wr(1, {4'h0, 8'h04, 20'd3000});
    wr(0, 32'hF);
    run_case(1500, 1, "R3");

    // R12 disabled: no evaluations, status held
    wr(0, 32'hE);
    repeat (2) @(negedge clk_i);
    count_evals(3500, n);
    chk(n == 0, "R12", "evals_while_disabled", n, 0);
    chk(mode_o == 3'd0 && width_o == 10'd1023, "R12", "mode_held", int'(mode_o), 0);

    // R13 output-side reset held, input side released
    wr(0, 32'hB);
    repeat (2) @(negedge clk_i);
    chk(mode_o == 3'd7 && width_o == 0, "R13", "status_reset", int'(mode_o), 7);
    chk(irq_stat_o == 0, "R13", "irq_reset", int'(irq_stat_o), 0);
    count_evals(3500, n);
    chk(n == 0, "R13", "evals_in_out_reset", n, 0);
    wr(0, 32'hF);
    prev_mode = 7; irq_exp = 0;
    run_case(1500, 1, "R13");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule